// File: doc/BRIEF.md
# Fetch Line Buffer with Shared Retry Slot

This block sits between an instruction-fetch stage and an instruction cache. It keeps one cache line per hardware thread and tells the fetch stage in the same cycle whether the line it asks for is already held. On a miss it sends a line-aligned read request to the cache. A request the cache refuses is parked in one slot shared by all threads, and that slot stops every thread from issuing until a retry pulse resends the request or the owning thread is squashed.

Each issued request carries a per-thread sequence tag. A response is written into a thread's line only when that thread is still waiting and the tag matches its latest request. Every other response is dropped and counted. A squash makes a thread forget its outstanding request and releases the retry slot if the thread owns it. While an interrupt is pending, new requests are held back. A parked request is still resent.

Each thread runs its own state machine. Its states are RUN (0), WAIT_RSP (1), WAIT_RETRY (2), DONE (3) and BLOCKED (4). The transitions are:
- *issue-accepted*: any state except WAIT_RSP or WAIT_RETRY goes to WAIT_RSP.
- *issue-refused*: the same states go to WAIT_RETRY.
- *resend-accepted*: WAIT_RETRY goes to WAIT_RSP.
- *fill*: WAIT_RSP goes to DONE, or to BLOCKED when the thread's stall is high.
- *unstall*: BLOCKED goes to DONE.
- *squash*: any state goes to RUN.

Top module: `fetch_line_buf`

## Requirements
- R1: A request address is the fetch PC with its low six bits cleared (64-byte lines). The same aligned value is used for the hit comparison.
- R2: `fetch_hit` is high in the same cycle when the fetching thread's line is valid and its address equals the aligned PC. In that cycle no request is sent.
- R3: On a miss the request goes out in the same cycle when the thread is in RUN, DONE or BLOCKED and nothing holds it. It carries tag = previous tag + 1, where tags reset to 0 and wrap at 2^TAG_W. After the clock edge the thread's line is invalid and it holds the new address.
- R4: A request refused (`creq_ready` low) puts the thread in WAIT_RETRY and sets `blocked`. While `blocked` is high no thread issues a new request.
- R5: A `retry_pulse` while a request is parked resends it with the same thread, address and tag. If accepted, the thread goes to WAIT_RSP and `blocked` clears. If refused, it stays parked. A pulse with no parked request has no effect.
- R6: A response for a thread in WAIT_RSP with a matching tag stores the line and marks it valid. The thread moves to BLOCKED (4) if its stall is high, otherwise to DONE (3).
- R7: Any other response (wrong tag, thread not in WAIT_RSP, or thread squashed in that cycle) changes no line or state and increments `drop_count` by one.
- R8: A squash sends the thread to RUN and overrides, in that cycle, any issue, resend or response for that thread. If the thread owns the parked request, the slot empties and `blocked` clears.
- R9: While `irq_pending` is high no new request is issued. A retry resend is still allowed.
- R10: A thread in BLOCKED moves to DONE in the cycle after its stall is low.
- R11: `thr_state` packs three bits per thread, with thread t at bits [3t+2:3t], using the encodings above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch lookup request this cycle |
| fetch_tid | input | TID_W | Thread of the lookup |
| fetch_pc | input | ADDR_W | Fetch address |
| irq_pending | input | 1 | Holds back new requests |
| fetch_hit | output | 1 | Lookup hits the buffered line |
| creq_valid | output | 1 | Cache request valid |
| creq_ready | input | 1 | Cache accepts the request this cycle |
| creq_tid | output | TID_W | Request thread |
| creq_addr | output | ADDR_W | Line-aligned request address |
| creq_tag | output | TAG_W | Request sequence tag |
| retry_pulse | input | 1 | Cache can take a refused request again |
| rsp_valid | input | 1 | Response valid |
| rsp_tid | input | TID_W | Response thread |
| rsp_tag | input | TAG_W | Response tag |
| rsp_data | input | LINE_W | Response line data |
| squash | input | NTHREADS | Per-thread squash |
| stall | input | NTHREADS | Per-thread downstream stall |
| thr_state | output | 3*NTHREADS | Per-thread state |
| line_valid | output | NTHREADS | Per-thread line valid |
| line_data | output | NTHREADS*LINE_W | Per-thread buffered line |
| blocked | output | 1 | Retry slot occupied, issue held |
| drop_count | output | CNT_W | Discarded-response counter (wraps) |

## Verification
The sharpest collisions come from a squash landing in the same cycle as another event for the same thread. The bench raises `retry_pulse` while squashing the owner of the parked request, and it delivers a tag-matching response in the same cycle that squashes its thread. It judges that no request leaves, that the slot and `blocked` clear, and that the response is counted as dropped while the line stays invalid. A behavioural model run alongside a long random phase also lands responses for one thread in the same cycle as another thread's issue or refusal.

// File: rtl/flb_pkg.sv
package flb_pkg;
    typedef enum logic [2:0] {
        TS_RUN        = 3'd0,
        TS_WAIT_RSP   = 3'd1,
        TS_WAIT_RETRY = 3'd2,
        TS_DONE       = 3'd3,
        TS_BLOCKED    = 3'd4
    } thr_state_e;
endpackage

// File: rtl/flb_thread_ctl.sv
module flb_thread_ctl
    import flb_pkg::*;
#(
    parameter int ID     = 0,
    parameter int TID_W  = 1,
    parameter int ADDR_W = 32,
    parameter int LINE_W = 512,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_go,
    input  logic              issue_acc,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              resend_acc,
    input  logic              rsp_valid,
    input  logic [TID_W-1:0]  rsp_tid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [LINE_W-1:0] rsp_data,
    input  logic              squash,
    input  logic              stall,
    output thr_state_e        state,
    output logic [ADDR_W-1:0] line_addr,
    output logic              line_vld,
    output logic [LINE_W-1:0] line_data,
    output logic [TAG_W-1:0]  out_tag,
    output logic              rsp_take
);
    thr_state_e st_n;

    assign rsp_take = rsp_valid && (rsp_tid == TID_W'(ID)) &&
                      (state == TS_WAIT_RSP) && (rsp_tag == out_tag) && !squash;

    always_comb begin
        st_n = state;
        if (squash) begin
            st_n = TS_RUN;
        end else if (issue_go) begin
            st_n = issue_acc ? TS_WAIT_RSP : TS_WAIT_RETRY;
        end else begin
            unique case (state)
                TS_WAIT_RETRY: if (resend_acc) st_n = TS_WAIT_RSP;
                TS_WAIT_RSP:   if (rsp_take) st_n = stall ? TS_BLOCKED : TS_DONE;
                TS_BLOCKED:    if (!stall) st_n = TS_DONE;
                default:       st_n = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TS_RUN;
        else        state <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_addr <= '0;
            line_vld  <= 1'b0;
            out_tag   <= '0;
            line_data <= '0;
        end else if (issue_go) begin
            line_addr <= issue_addr;
            line_vld  <= 1'b0;
            out_tag   <= out_tag + TAG_W'(1);
        end else if (rsp_take) begin
            line_vld  <= 1'b1;
            line_data <= rsp_data;
        end
    end

    assert_tag_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_go |=> out_tag == $past(out_tag) + TAG_W'(1));
    assert_issue_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_go |=> !line_vld && (state == TS_WAIT_RSP || state == TS_WAIT_RETRY));
    assert_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_take |=> line_vld && (state == TS_DONE || state == TS_BLOCKED));
    assert_squash_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> state == TS_RUN);
    assert_unstall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_BLOCKED && !stall && !squash && !issue_go) |=> state == TS_DONE);
endmodule

// File: rtl/flb_retry_slot.sv
module flb_retry_slot #(
    parameter int NT     = 2,
    parameter int TID_W  = 1,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              park,
    input  logic [TID_W-1:0]  park_tid,
    input  logic [ADDR_W-1:0] park_addr,
    input  logic [TAG_W-1:0]  park_tag,
    input  logic              resend_acc,
    input  logic [NT-1:0]     squash,
    output logic              full,
    output logic [TID_W-1:0]  slot_tid,
    output logic [ADDR_W-1:0] slot_addr,
    output logic [TAG_W-1:0]  slot_tag
);
    logic own_squash;
    assign own_squash = full && squash[slot_tid];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            slot_tid  <= '0;
            slot_addr <= '0;
            slot_tag  <= '0;
        end else if (park) begin
            full      <= 1'b1;
            slot_tid  <= park_tid;
            slot_addr <= park_addr;
            slot_tag  <= park_tag;
        end else if (full && (resend_acc || own_squash)) begin
            full <= 1'b0;
        end
    end

    assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        park |-> !full);
    assert_park_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        park |=> full);
    assert_squash_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (own_squash && !park) |=> !full);
    assert_resend_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && resend_acc) |=> !full);
endmodule

// File: rtl/flb_req_path.sv
module flb_req_path #(
    parameter int NT     = 2,
    parameter int TID_W  = 1,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 3,
    parameter int OFF_W  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fetch_valid,
    input  logic [TID_W-1:0]           fetch_tid,
    input  logic [ADDR_W-1:0]          fetch_pc,
    input  logic                       irq_hold,
    input  logic                       retry_pulse,
    input  logic                       creq_ready,
    input  logic [NT-1:0]              squash,
    input  logic [NT-1:0]              line_vld,
    input  logic [NT-1:0][ADDR_W-1:0]  line_addr,
    input  logic [NT-1:0]              thr_busy,
    input  logic [NT-1:0][TAG_W-1:0]   out_tag,
    input  logic                       slot_full,
    input  logic [TID_W-1:0]           slot_tid,
    input  logic [ADDR_W-1:0]          slot_addr,
    input  logic [TAG_W-1:0]           slot_tag,
    output logic                       fetch_hit,
    output logic                       creq_valid,
    output logic [TID_W-1:0]           creq_tid,
    output logic [ADDR_W-1:0]          creq_addr,
    output logic [TAG_W-1:0]           creq_tag,
    output logic [NT-1:0]              issue_go,
    output logic [ADDR_W-1:0]          issue_addr,
    output logic                       resend_acc,
    output logic                       park
);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);

    logic resend_try, new_try;

    assign issue_addr = fetch_pc & ~OFF_MASK;
    assign fetch_hit  = fetch_valid && line_vld[fetch_tid] &&
                        (line_addr[fetch_tid] == issue_addr);
    assign resend_try = retry_pulse && slot_full && !squash[slot_tid];
    assign new_try    = fetch_valid && !fetch_hit && !slot_full && !irq_hold &&
                        !squash[fetch_tid] && !thr_busy[fetch_tid];

    always_comb begin
        creq_valid = resend_try || new_try;
        if (resend_try) begin
            creq_tid  = slot_tid;
            creq_addr = slot_addr;
            creq_tag  = slot_tag;
        end else begin
            creq_tid  = fetch_tid;
            creq_addr = issue_addr;
            creq_tag  = out_tag[fetch_tid] + TAG_W'(1);
        end
    end

    for (genvar t = 0; t < NT; t++) begin : g_go
        assign issue_go[t] = new_try && (fetch_tid == TID_W'(t));
    end

    assign resend_acc = resend_try && creq_ready;
    assign park       = new_try && !creq_ready;

    assert_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
        creq_valid |-> (creq_addr & OFF_MASK) == '0);
    assert_single_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_go));
    assert_hit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_hit && !slot_full) |-> !creq_valid);
endmodule

// File: rtl/fetch_line_buf.sv
module fetch_line_buf
    import flb_pkg::*;
#(
    parameter int NTHREADS   = 2,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int TAG_W      = 3,
    parameter int CNT_W      = 8,
    localparam int TID_W     = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fetch_valid,
    input  logic [TID_W-1:0]             fetch_tid,
    input  logic [ADDR_W-1:0]            fetch_pc,
    input  logic                         irq_pending,
    output logic                         fetch_hit,
    output logic                         creq_valid,
    input  logic                         creq_ready,
    output logic [TID_W-1:0]             creq_tid,
    output logic [ADDR_W-1:0]            creq_addr,
    output logic [TAG_W-1:0]             creq_tag,
    input  logic                         retry_pulse,
    input  logic                         rsp_valid,
    input  logic [TID_W-1:0]             rsp_tid,
    input  logic [TAG_W-1:0]             rsp_tag,
    input  logic [LINE_W-1:0]            rsp_data,
    input  logic [NTHREADS-1:0]          squash,
    input  logic [NTHREADS-1:0]          stall,
    output logic [3*NTHREADS-1:0]        thr_state,
    output logic [NTHREADS-1:0]          line_valid,
    output logic [NTHREADS*LINE_W-1:0]   line_data,
    output logic                         blocked,
    output logic [CNT_W-1:0]             drop_count
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    thr_state_e                      st      [NTHREADS];
    logic [NTHREADS-1:0][ADDR_W-1:0] l_addr;
    logic [NTHREADS-1:0][TAG_W-1:0]  o_tag;
    logic [NTHREADS-1:0]             busy, take, go;
    logic [ADDR_W-1:0]               iss_addr;
    logic                            res_acc, park;
    logic                            s_full;
    logic [TID_W-1:0]                s_tid;
    logic [ADDR_W-1:0]               s_addr;
    logic [TAG_W-1:0]                s_tag;
    logic                            drop;

    flb_req_path #(.NT(NTHREADS), .TID_W(TID_W), .ADDR_W(ADDR_W),
                   .TAG_W(TAG_W), .OFF_W(OFF_W)) u_req (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_tid(fetch_tid), .fetch_pc(fetch_pc),
        .irq_hold(irq_pending), .retry_pulse(retry_pulse), .creq_ready(creq_ready),
        .squash(squash), .line_vld(line_valid), .line_addr(l_addr),
        .thr_busy(busy), .out_tag(o_tag),
        .slot_full(s_full), .slot_tid(s_tid), .slot_addr(s_addr), .slot_tag(s_tag),
        .fetch_hit(fetch_hit), .creq_valid(creq_valid), .creq_tid(creq_tid),
        .creq_addr(creq_addr), .creq_tag(creq_tag), .issue_go(go),
        .issue_addr(iss_addr), .resend_acc(res_acc), .park(park)
    );

    flb_retry_slot #(.NT(NTHREADS), .TID_W(TID_W), .ADDR_W(ADDR_W),
                     .TAG_W(TAG_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .park(park), .park_tid(fetch_tid), .park_addr(iss_addr),
        .park_tag(o_tag[fetch_tid] + TAG_W'(1)),
        .resend_acc(res_acc), .squash(squash),
        .full(s_full), .slot_tid(s_tid), .slot_addr(s_addr), .slot_tag(s_tag)
    );

    for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
        flb_thread_ctl #(.ID(t), .TID_W(TID_W), .ADDR_W(ADDR_W),
                         .LINE_W(LINE_W), .TAG_W(TAG_W)) u_thr (
            .clk(clk), .rst_n(rst_n),
            .issue_go(go[t]), .issue_acc(creq_ready), .issue_addr(iss_addr),
            .resend_acc(res_acc && (s_tid == TID_W'(t))),
            .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_tag(rsp_tag),
            .rsp_data(rsp_data), .squash(squash[t]), .stall(stall[t]),
            .state(st[t]), .line_addr(l_addr[t]), .line_vld(line_valid[t]),
            .line_data(line_data[t*LINE_W +: LINE_W]), .out_tag(o_tag[t]),
            .rsp_take(take[t])
        );
        assign busy[t]            = (st[t] == TS_WAIT_RSP) || (st[t] == TS_WAIT_RETRY);
        assign thr_state[3*t +: 3] = st[t];
    end

    assign blocked = s_full;
    assign drop    = rsp_valid && !(|take);

    always_ff @(posedge clk) begin
        if (!rst_n)    drop_count <= '0;
        else if (drop) drop_count <= drop_count + CNT_W'(1);
    end

    assert_drop_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> drop_count == $past(drop_count) + CNT_W'(1));
    assert_blocked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> go == '0);
    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> go == '0);
    assert_single_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));
endmodule

// File: tb/fetch_line_buf_test.sv
`timescale 1ns/1ps
module fetch_line_buf_test;
    localparam int NT = 2;
    localparam int LW = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          fv = 0, irq = 0, rdy = 0, rp = 0, rv = 0;
    logic [0:0]    ftid = 0, rtid = 0;
    logic [31:0]   fpc = 0;
    logic [2:0]    rtag = 0;
    logic [LW-1:0] rdat = '0;
    logic [NT-1:0] sq = 0, stl = 0;

    logic          hit, cv, blk;
    logic [0:0]    ctid;
    logic [31:0]   caddr;
    logic [2:0]    ctag;
    logic [3*NT-1:0]  tst;
    logic [NT-1:0]    lv;
    logic [NT*LW-1:0] ld;
    logic [7:0]       dcnt;

    fetch_line_buf uut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fv), .fetch_tid(ftid), .fetch_pc(fpc),
        .irq_pending(irq), .fetch_hit(hit), .creq_valid(cv), .creq_ready(rdy),
        .creq_tid(ctid), .creq_addr(caddr), .creq_tag(ctag), .retry_pulse(rp),
        .rsp_valid(rv), .rsp_tid(rtid), .rsp_tag(rtag), .rsp_data(rdat),
        .squash(sq), .stall(stl), .thr_state(tst), .line_valid(lv), .line_data(ld),
        .blocked(blk), .drop_count(dcnt)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    string cur = "R11";

    // behavioural reference
    int          m_st [NT];
    logic [31:0] m_addr [NT];
    bit          m_vld [NT];
    logic [LW-1:0] m_data [NT];
    int          m_tag [NT];
    bit          s_full;
    int          s_tid, s_tag;
    logic [31:0] s_addr;
    int          m_drop;

    task automatic chk(string req, string sig, logic [LW-1:0] got, logic [LW-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) %s: actual %0h expected %0h at %0t", req, cur, sig, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            m_st[t] = 0; m_addr[t] = 0; m_vld[t] = 0; m_data[t] = '0; m_tag[t] = 0;
        end
        s_full = 0; s_tid = 0; s_tag = 0; s_addr = 0; m_drop = 0;
    endtask

    // compare outputs for current inputs, then advance model one clock
    task automatic tick();
        logic [31:0] al;
        bit e_hit, resend, newi, any_take;
        bit take [NT];
        #1;
        al     = fpc & 32'hFFFF_FFC0;
        e_hit  = fv && m_vld[ftid] && (m_addr[ftid] == al);
        resend = rp && s_full && !sq[s_tid];
        newi   = fv && !e_hit && !s_full && !irq && !sq[ftid] &&
                 !(m_st[ftid] == 1 || m_st[ftid] == 2);
        chk("R2", "fetch_hit", LW'(hit), LW'(e_hit));
        chk("R3", "creq_valid", LW'(cv), LW'(resend || newi));
        if (resend) begin
            chk("R5", "creq_tid", LW'(ctid), LW'(s_tid));
            chk("R5", "creq_addr", LW'(caddr), LW'(s_addr));
            chk("R5", "creq_tag", LW'(ctag), LW'(s_tag));
        end else if (newi) begin
            chk("R3", "creq_tid", LW'(ctid), LW'(ftid));
            chk("R1", "creq_addr", LW'(caddr), LW'(al));
            chk("R3", "creq_tag", LW'(ctag), LW'((m_tag[ftid] + 1) % 8));
        end
        chk("R4", "blocked", LW'(blk), LW'(s_full));
        chk("R7", "drop_count", LW'(dcnt), LW'(m_drop % 256));
        for (int t = 0; t < NT; t++) begin
            chk("R11", "thr_state", LW'(tst[3*t +: 3]), LW'(m_st[t]));
            chk("R6", "line_valid", LW'(lv[t]), LW'(m_vld[t]));
            if (m_vld[t]) chk("R6", "line_data", ld[t*LW +: LW], m_data[t]);
        end
        // next state
        any_take = 0;
        for (int t = 0; t < NT; t++) begin
            take[t] = rv && (rtid == t) && (m_st[t] == 1) && (rtag == m_tag[t]) && !sq[t];
            if (take[t]) any_take = 1;
        end
        if (rv && !any_take) m_drop++;
        for (int t = 0; t < NT; t++) begin
            if (sq[t]) m_st[t] = 0;
            else if (newi && ftid == t) begin
                m_addr[t] = al; m_vld[t] = 0; m_tag[t] = (m_tag[t] + 1) % 8;
                m_st[t] = rdy ? 1 : 2;
            end else if (resend && rdy && s_tid == t) m_st[t] = 1;
            else if (take[t]) begin
                m_vld[t] = 1; m_data[t] = rdat; m_st[t] = stl[t] ? 4 : 3;
            end else if (m_st[t] == 4 && !stl[t]) m_st[t] = 3;
        end
        if (newi && !rdy) begin
            s_full = 1; s_tid = ftid; s_addr = al; s_tag = m_tag[ftid];
        end else if (s_full && ((resend && rdy) || sq[s_tid])) s_full = 0;
        @(negedge clk);
    endtask

    task automatic idle();
        fv = 0; irq = 0; rdy = 0; rp = 0; rv = 0; sq = 0; stl = 0;
        rdat = {16{$urandom}};
    endtask

    task automatic fetch(int t, logic [31:0] pc, bit r);
        idle(); fv = 1; ftid = 1'(t); fpc = pc; rdy = r;
    endtask

    task automatic resp(int t, int tg);
        idle(); rv = 1; rtid = 1'(t); rtag = 3'(tg);
        for (int w = 0; w < 16; w++) rdat[w*32 +: 32] = $urandom;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur = "R11"; tick();                       // reset state
        cur = "R1";  fetch(0, 32'h0000_1234, 1); tick();   // issue tag 1
        cur = "R7";  resp(0, 2); tick();           // wrong tag
        resp(1, 0); tick();                        // thread not waiting
        cur = "R6";  resp(0, 1); tick();           // fill -> DONE
        cur = "R2";  fetch(0, 32'h0000_1238, 1); tick();   // hit
        fetch(0, 32'h0000_1240, 1); tick();        // new line, tag 2
        cur = "R10"; resp(0, 2); stl = 2'b01; tick();      // fill -> BLOCKED
        idle(); stl = 2'b01; tick();
        idle(); tick();                            // -> DONE
        cur = "R4";  fetch(1, 32'h0000_8004, 0); tick();   // refused, parked
        fetch(0, 32'h0000_9000, 1); tick();        // held
        cur = "R5";  idle(); rp = 1; rdy = 0; tick();      // resend refused
        idle(); rp = 1; rdy = 1; tick();           // resend accepted
        cur = "R9";  fetch(0, 32'h0000_A000, 1); irq = 1; tick();
        idle(); rp = 1; rdy = 1; tick();           // empty slot pulse
        cur = "R8";  fetch(0, 32'h0000_B000, 0); tick();   // park thread 0
        idle(); rp = 1; rdy = 1; sq = 2'b01; tick();       // squash owner with resend
        resp(1, 1); sq = 2'b10; tick();            // squash beats matching response
        fetch(1, 32'h0000_8000, 1); tick();        // reissue tag 2
        resp(1, 1); tick();                        // stale tag dropped
        resp(1, 2); tick();                        // accepted
        // random phase
        cur = "R3";
        for (int i = 0; i < 4000; i++) begin
            idle();
            fv   = ($urandom % 3) != 0;
            ftid = 1'($urandom);
            fpc  = (($urandom % 4) << 6) | ($urandom % 64);
            rdy  = ($urandom % 4) != 0;
            rp   = ($urandom % 4) == 0;
            irq  = ($urandom % 10) == 0;
            sq   = (($urandom % 12) == 0) ? 2'(1 << ($urandom % 2)) : 2'b00;
            stl  = 2'($urandom % 4);
            rv   = ($urandom % 2) == 0;
            rtid = 1'($urandom);
            rtag = (($urandom % 4) != 0) ? 3'(m_tag[rtid]) : 3'($urandom);
            for (int w = 0; w < 16; w++) rdat[w*32 +: 32] = $urandom;
            tick();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule